// File: doc/BRIEF.md
# Start-Up Ramp and Output Protection Supervisor

This block brings a multiphase buck regulator up and then watches its output. Once both supply flags report good and the inhibit input is inactive, it ramps the loop reference from zero to the programmed target code. The ramp takes exactly 2048 clock periods. After the ramp it holds the reference at the target.

Every clock it compares a digitized output-voltage code with three limits:
- a power-good window around the target;
- an undervoltage limit that follows the reference while it ramps;
- an overvoltage limit that is fixed to the final target.

An undervoltage trip turns every power switch off. An overvoltage trip forces both low-side switches on and both high-side switches off. In both cases the fault output goes high and stays high until a supply flag drops.

All codes share one fixed-point scale. With the default width of 10 bits, code 300 stands for the 0.6 V arming point.

The control is a state machine with six states:
- `ST_OFF`: waiting for the supplies.
- `ST_INH`: inhibited.
- `ST_RAMP`: soft start in progress.
- `ST_RUN`: regulating at the target.
- `ST_UVF`: latched undervoltage fault.
- `ST_OVF`: latched overvoltage fault.

Transitions:
- `ST_OFF`→`ST_RAMP` when both supplies are good and inhibit is low.
- `ST_OFF`→`ST_INH` when both supplies are good and inhibit is high.
- `ST_INH`→`ST_RAMP` when inhibit is released.
- `ST_RAMP`→`ST_RUN` when the ramp completes.
- `ST_RAMP`/`ST_RUN`→`ST_OVF` on overvoltage.
- `ST_RAMP`/`ST_RUN`→`ST_UVF` on a persistent undervoltage.
- `ST_RAMP`/`ST_RUN`→`ST_INH` when inhibit is asserted.
- Any state→`ST_OFF` when a supply flag drops.

When several conditions hold at once, the priority is supply loss, then inhibit, then overvoltage, then undervoltage.

Top module: `sstart_guard`

## Requirements
- R1: Let T be `target_code`. `ref_code` stays at or below T. On the clock edge where the ramp starts, `ref_code` becomes 0. After the n-th further edge (n from 1 to 2047) it equals floor(T·n/2048). After the 2048th further edge it equals T, and it holds there while running.
- R2: While `vcc_ok` and `drv_ok` are not both high, no ramp starts. In that case `ref_code` is 0, `sw_off` is 1 and `fault` is 0.
- R3: `pgood` is 0 during the ramp. After the ramp, `pgood` is 1 exactly when the sensed code S satisfies T−D ≤ S ≤ T+D, where D = (T>>3)−(T>>8), which is about 12 %.
- R4: Undervoltage checking is armed only while `ref_code` ≥ `UV_ARM` (default 300).
- R5: An undervoltage trip occurs when S < L on two consecutive clock edges. L is computed from the current reference r as L = (r>>1)+(r>>4)+(r>>5)+(r>>8), which is about 60 %. After the trip, `fault`=1, `sw_off`=1, `ls_crowbar`=0 and `ref_code`=0.
- R6: An overvoltage trip occurs when S > T+(T>>3)+(T>>4) on any single edge during the ramp or while running. The limit therefore uses the target, not the ramping reference. After the trip, `fault`=1, `ls_crowbar`=1 and `sw_off`=0.
- R7: A tripped fault, together with its switch command, stays latched through any sense value and any inhibit activity. When a supply flag drops, the block returns to the off state with `fault`=0.
- R8: On the edge after `inhibit` is asserted, `sw_off`=1, `ref_code`=0 and `pgood`=0. While inhibited, no fault can trip. Releasing inhibit restarts the ramp from zero.
- R9: If a supply flag drops during the ramp or while running, the block is in the off state on the next edge. The ramp restarts from zero once both supplies are good again.
- R10: While reset is active, `ref_code`=0, `pgood`=0, `fault`=0, `sw_off`=1 and `ls_crowbar`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per switching period |
| rst_n | input | 1 | Asynchronous reset, active low |
| vcc_ok | input | 1 | Controller supply above its turn-on threshold |
| drv_ok | input | 1 | Driver supply above its turn-on threshold |
| inhibit | input | 1 | High holds the block disabled |
| target_code | input | DW | Programmed target reference code |
| sense_code | input | DW | Digitized output voltage, same scale as the target |
| ref_code | output | DW | Reference code passed to the regulation loop |
| pgood | output | 1 | Output voltage inside the good window after the ramp |
| fault | output | 1 | Latched under- or overvoltage fault |
| sw_off | output | 1 | Command to turn every power switch off |
| ls_crowbar | output | 1 | Command to force low-side switches on and high-side switches off |

## Verification
The state register is the only stage between the inputs and the outputs, and the outputs decode its value. A change of state is therefore visible right after the clock edge that samples its cause. `pgood` and `ref_code` also follow `sense_code` and the ramp counter in that same cycle.

The bench changes inputs 1 ns after a rising edge and samples 1 ns after the next one. It counts ramp edges from the edge that starts the ramp, so that each reference value is compared after the n-th edge. An overvoltage result is checked one edge after the stimulus and an undervoltage result two edges after. At the arming point, the bench checks that the edge before the trip still shows no fault.

// File: rtl/sstart_guard_pkg.sv
package sstart_guard_pkg;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_INH  = 3'd1,
        ST_RAMP = 3'd2,
        ST_RUN  = 3'd3,
        ST_UVF  = 3'd4,
        ST_OVF  = 3'd5
    } sup_state_t;

endpackage

// File: rtl/sstart_ramp.sv
module sstart_ramp #(
    parameter int DW      = 10,
    parameter int SS_LOG2 = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [DW-1:0] tgt,
    output logic [DW-1:0] ramp_ref,
    output logic          ramp_done
);
    localparam int                  PW       = DW + SS_LOG2;
    localparam logic [SS_LOG2-1:0]  CNT_LAST = '1;

    logic [SS_LOG2-1:0] step_cnt;
    logic [PW-1:0]      prod;

    // Counter is cleared whenever the ramp is not active, so each entry starts at zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_cnt <= '0;
        end else if (run_en) begin
            step_cnt <= step_cnt + 1'b1;
        end else begin
            step_cnt <= '0;
        end
    end

    assign prod      = {{SS_LOG2{1'b0}}, tgt} * {{DW{1'b0}}, step_cnt};
    assign ramp_ref  = prod[PW-1:SS_LOG2];
    assign ramp_done = run_en && (step_cnt == CNT_LAST);

    // R1
    step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !ramp_done) |=> (step_cnt == $past(step_cnt) + 1'b1));

endmodule

// File: rtl/sstart_limits.sv
module sstart_limits #(
    parameter int DW = 10
) (
    input  logic [DW-1:0] tgt,
    input  logic [DW-1:0] rf,
    output logic [DW-1:0] pg_lo,
    output logic [DW:0]   pg_hi,
    output logic [DW:0]   ov_lim,
    output logic [DW-1:0] uv_lim
);
    logic [DW:0]   tgt_x;
    logic [DW-1:0] pg_band;

    assign tgt_x   = {1'b0, tgt};
    // Window half-width of about 12 %: one eighth less one two-hundred-fifty-sixth.
    assign pg_band = (tgt >> 3) - (tgt >> 8);
    assign pg_lo   = tgt - pg_band;
    assign pg_hi   = tgt_x + {1'b0, pg_band};
    // Overvoltage at about 119 % of the final target.
    assign ov_lim  = tgt_x + {1'b0, tgt >> 3} + {1'b0, tgt >> 4};
    // Undervoltage at about 60 % of the moving reference.
    assign uv_lim  = (rf >> 1) + (rf >> 4) + (rf >> 5) + (rf >> 8);

endmodule

// File: rtl/sstart_guard.sv
module sstart_guard
    import sstart_guard_pkg::*;
#(
    parameter int DW      = 10,
    parameter int SS_LOG2 = 11,
    parameter int UV_ARM  = 300
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vcc_ok,
    input  logic          drv_ok,
    input  logic          inhibit,
    input  logic [DW-1:0] target_code,
    input  logic [DW-1:0] sense_code,
    output logic [DW-1:0] ref_code,
    output logic          pgood,
    output logic          fault,
    output logic          sw_off,
    output logic          ls_crowbar
);
    localparam logic [DW-1:0] ARM_CODE = DW'(UV_ARM);

    sup_state_t    st, st_nxt;
    logic          sup_ok, active, ramping;
    logic [DW-1:0] ramp_ref;
    logic          ramp_done;
    logic [DW-1:0] pg_lo, uv_lim;
    logic [DW:0]   pg_hi, ov_lim, sense_x;
    logic          ov_now, uv_now, uv_seen, in_win;

    assign sup_ok  = vcc_ok && drv_ok;
    assign ramping = (st == ST_RAMP);
    assign active  = (st == ST_RAMP) || (st == ST_RUN);
    assign sense_x = {1'b0, sense_code};

    sstart_ramp #(.DW(DW), .SS_LOG2(SS_LOG2)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (ramping),
        .tgt       (target_code),
        .ramp_ref  (ramp_ref),
        .ramp_done (ramp_done)
    );

    sstart_limits #(.DW(DW)) u_lim (
        .tgt    (target_code),
        .rf     (ref_code),
        .pg_lo  (pg_lo),
        .pg_hi  (pg_hi),
        .ov_lim (ov_lim),
        .uv_lim (uv_lim)
    );

    assign ov_now = active && (sense_x > ov_lim);
    assign uv_now = active && (ref_code >= ARM_CODE) && (sense_code < uv_lim);
    assign in_win = (sense_code >= pg_lo) && (sense_x <= pg_hi);

    // Undervoltage persistence: remembers the condition from the previous edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uv_seen <= 1'b0;
        end else begin
            uv_seen <= uv_now;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_OFF;
        end else begin
            st <= st_nxt;
        end
    end

    // Next-state logic; priority: supply loss, inhibit, overvoltage, undervoltage.
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_OFF: begin
                if (sup_ok) st_nxt = inhibit ? ST_INH : ST_RAMP;
            end
            ST_INH: begin
                if (!sup_ok)      st_nxt = ST_OFF;
                else if (!inhibit) st_nxt = ST_RAMP;
            end
            ST_RAMP, ST_RUN: begin
                if (!sup_ok)                  st_nxt = ST_OFF;
                else if (inhibit)             st_nxt = ST_INH;
                else if (ov_now)              st_nxt = ST_OVF;
                else if (uv_now && uv_seen)   st_nxt = ST_UVF;
                else if (ramping && ramp_done) st_nxt = ST_RUN;
            end
            ST_UVF, ST_OVF: begin
                if (!sup_ok) st_nxt = ST_OFF;
            end
            default: st_nxt = ST_OFF;
        endcase
    end

    // Outputs decoded from the state register
    always_comb begin
        ref_code   = '0;
        pgood      = 1'b0;
        fault      = 1'b0;
        sw_off     = 1'b1;
        ls_crowbar = 1'b0;
        unique case (st)
            ST_OFF, ST_INH: begin
                sw_off = 1'b1;
            end
            ST_RAMP: begin
                sw_off   = 1'b0;
                ref_code = ramp_ref;
            end
            ST_RUN: begin
                sw_off   = 1'b0;
                ref_code = target_code;
                pgood    = in_win;
            end
            ST_UVF: begin
                fault  = 1'b1;
                sw_off = 1'b1;
            end
            ST_OVF: begin
                fault      = 1'b1;
                sw_off     = 1'b0;
                ls_crowbar = 1'b1;
            end
            default: begin
                sw_off = 1'b1;
            end
        endcase
    end

    // R1
    ref_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_code <= target_code);

    // R2
    no_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_ok |=> (sw_off && !fault && ref_code == '0));

    // R3
    pgood_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgood |-> (!sw_off && !fault && ref_code == target_code));

    // R5
    uv_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_ok && !inhibit && !ov_now && uv_now && uv_seen) |=> (fault && sw_off && !ls_crowbar));

    // R6
    ov_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_ok && !inhibit && ov_now) |=> (fault && ls_crowbar && !sw_off));

    // R7
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && sup_ok) |=> fault);

    // R8
    inhibit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && sup_ok) |=> ((sw_off || fault) && !pgood));

endmodule

// File: tb/sstart_guard_tb.sv
module sstart_guard_tb;
    localparam int DW = 10;
    localparam int NV = 9;
    localparam int TGT = 700;
    localparam int VS [NV] = '{700, 615, 614, 785, 786, 830, 500, 417, 416};
    localparam int VP [NV] = '{1,   1,   0,   1,   0,   0,   0,   0,   0};

    logic          clk = 1'b0;
    logic          rst_n, vcc_ok, drv_ok, inhibit;
    logic [DW-1:0] target_code, sense_code, ref_code;
    logic          pgood, fault, sw_off, ls_crowbar;
    int            checks = 0;
    int            fails  = 0;

    always #2 clk = ~clk;

    sstart_guard #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .drv_ok(drv_ok),
        .inhibit(inhibit), .target_code(target_code), .sense_code(sense_code),
        .ref_code(ref_code), .pgood(pgood), .fault(fault),
        .sw_off(sw_off), .ls_crowbar(ls_crowbar)
    );

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; vcc_ok = 1'b0; drv_ok = 1'b0; inhibit = 1'b0;
        target_code = DW'(TGT); sense_code = DW'(TGT);
        tick(2);
        // R10 reset state
        chk("R10", "ref", int'(ref_code), 0);
        chk("R10", "pgood", int'(pgood), 0);
        chk("R10", "fault", int'(fault), 0);
        chk("R10", "sw_off", int'(sw_off), 1);
        chk("R10", "crowbar", int'(ls_crowbar), 0);
        rst_n = 1'b1;

        // R2 one supply only
        vcc_ok = 1'b1;
        tick(5);
        chk("R2", "sw_off", int'(sw_off), 1);
        chk("R2", "ref", int'(ref_code), 0);

        // R1 ramp timing
        drv_ok = 1'b1;
        tick();
        chk("R1", "ref at start", int'(ref_code), 0);
        chk("R1", "sw_off at start", int'(sw_off), 0);
        tick(1024);
        chk("R1", "ref mid", int'(ref_code), 350);
        chk("R3", "pgood in ramp", int'(pgood), 0);
        tick(1023);
        chk("R1", "ref last ramp step", int'(ref_code), 699);
        chk("R3", "pgood end ramp", int'(pgood), 0);
        tick();
        chk("R1", "ref at target", int'(ref_code), TGT);
        chk("R3", "pgood running", int'(pgood), 1);

        // R3 window table
        for (int k = 0; k < NV; k++) begin
            sense_code = DW'(VS[k]);
            tick();
            chk("R3", $sformatf("pgood sense %0d", VS[k]), int'(pgood), VP[k]);
            chk("R3", $sformatf("no fault sense %0d", VS[k]), int'(fault), 0);
        end

        // R5 persistence
        sense_code = 10'd415;
        tick();
        chk("R5", "single low sample", int'(fault), 0);
        sense_code = 10'd700;
        tick();
        sense_code = 10'd415;
        tick();
        chk("R5", "first low edge", int'(fault), 0);
        tick();
        chk("R5", "uv fault", int'(fault), 1);
        chk("R5", "uv sw_off", int'(sw_off), 1);
        chk("R5", "uv crowbar", int'(ls_crowbar), 0);
        chk("R5", "uv ref", int'(ref_code), 0);

        // R7 latch through inhibit and good sense
        sense_code = 10'd700;
        inhibit = 1'b1;
        tick(3);
        inhibit = 1'b0;
        tick(3);
        chk("R7", "uv latched", int'(fault), 1);
        vcc_ok = 1'b0;
        tick();
        chk("R7", "cleared by supply", int'(fault), 0);
        chk("R7", "off after clear", int'(sw_off), 1);

        // R4 arming point during ramp with zero sense
        vcc_ok = 1'b1;
        sense_code = '0;
        tick();
        tick(879);
        chk("R4", "not tripped before arm", int'(fault), 0);
        tick();
        chk("R4", "uv trip once armed", int'(fault), 1);
        chk("R5", "uv trip sw_off", int'(sw_off), 1);

        // R6 overvoltage during ramp
        drv_ok = 1'b0;
        tick();
        drv_ok = 1'b1;
        sense_code = 10'd700;
        tick();
        tick(100);
        sense_code = 10'd831;
        tick();
        chk("R6", "ov fault", int'(fault), 1);
        chk("R6", "ov crowbar", int'(ls_crowbar), 1);
        chk("R6", "ov sw_off", int'(sw_off), 0);
        sense_code = 10'd700;
        tick(3);
        chk("R7", "ov latched", int'(ls_crowbar), 1);

        // back to running
        vcc_ok = 1'b0;
        tick();
        vcc_ok = 1'b1;
        tick();
        tick(2048);
        chk("R1", "ref after second ramp", int'(ref_code), TGT);
        sense_code = 10'd830;
        tick();
        chk("R6", "at ov limit no trip", int'(fault), 0);
        sense_code = 10'd700;

        // R8 inhibit
        inhibit = 1'b1;
        tick();
        chk("R8", "inh sw_off", int'(sw_off), 1);
        chk("R8", "inh ref", int'(ref_code), 0);
        chk("R8", "inh pgood", int'(pgood), 0);
        sense_code = 10'd900;
        tick(3);
        chk("R8", "no ov while inhibited", int'(fault), 0);
        sense_code = '0;
        tick(3);
        chk("R8", "no uv while inhibited", int'(fault), 0);
        sense_code = 10'd700;
        inhibit = 1'b0;
        tick();
        chk("R8", "restart ref", int'(ref_code), 0);
        chk("R8", "restart sw_off", int'(sw_off), 0);
        tick(1024);
        chk("R8", "restart ramp mid", int'(ref_code), 350);

        // R9 supply loss mid-ramp
        drv_ok = 1'b0;
        tick();
        chk("R9", "loss sw_off", int'(sw_off), 1);
        chk("R9", "loss ref", int'(ref_code), 0);
        chk("R9", "loss fault", int'(fault), 0);
        drv_ok = 1'b1;
        tick();
        chk("R9", "restart ref", int'(ref_code), 0);
        tick(1024);
        chk("R9", "restart ramp mid", int'(ref_code), 350);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule